// File: doc/BRIEF.md
# Four-State Moore Recognizer with Selectable State Encoding

This block watches a single serial bit and raises its output while the machine is in its one accepting state. It has four states and one transition table. The output depends only on the present state.

The way the states are stored is chosen when the design is elaborated:

- **Binary.** Two flip-flops. The next-state bits and the output come from hand-written sum-of-products equations.
- **One-hot.** Four flip-flops, one per state. Any one-hot word that cannot be reached (all zero, or more than one bit set) goes back to the starting state on the next edge.

Both variants must look the same at the ports on every cycle, so either one can be dropped into a design and the two can be compared directly.

The encoding parameter takes only the values 0 (binary) and 1 (one-hot). Any other value stops elaboration with an error.

Top module: `moore_seq`

## Requirements
- R1: The synchronous, active-high reset `rst` puts the machine in the start state S0 at the next rising edge. From the cycle after that edge `u_out` is 0. Reset takes priority over `x_in`.
- R2: `u_out` is 1 only in the accepting state S3 and is 0 in S0, S1 and S2. It changes only just after a rising clock edge.
- R3: In S0, `x_in`=1 keeps the machine in S0 and `x_in`=0 moves it to S1.
- R4: In S1, `x_in`=0 keeps the machine in S1 and `x_in`=1 moves it to S2.
- R5: In S2, `x_in`=0 moves the machine to S3 and `x_in`=1 sends it back to S0.
- R6: In S3, `x_in`=0 moves the machine to S1 and `x_in`=1 moves it to S0. S3 therefore never lasts two cycles in a row.
- R7: From S0, the inputs 0,1,0 on three consecutive edges raise `u_out` just after the third edge. A following 1 returns the machine to S0, where a further 1 keeps `u_out` low.
- R8: With `ENC`=0 (binary) and `ENC`=1 (one-hot), the block produces the same `u_out` on every cycle for the same input and reset sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to S0 |
| x_in | input | 1 | Serial input bit, sampled on each rising edge |
| u_out | output | 1 | Moore output, high in state S3 only |

## Verification
Two things can fall on the same edge: reset, and a transition that would enter or leave S3.

The bench steers both encodings into S2 and then asserts reset while `x_in` is 0. Without reset, this input would take the machine into S3. The bench also asserts reset while the machine already sits in S3.

A correct result has `u_out` low on the following cycle in both instances. Afterwards the machine must behave as a fresh S0: a 0,1,0 pattern has to reach S3 again. Random runs also assert reset from time to time, at whatever state the machine happens to be in, and each result is judged against the bench's own transition model.

// File: rtl/moore_seq.sv
module moore_seq #(
  parameter int ENC = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic u_out
);

  generate
    if (ENC == 0) begin : g_bin
      logic [1:0] y;
      logic [1:0] y_nx;

      assign y_nx[1] = (~x_in & y[1] & ~y[0]) | (x_in & ~y[1] & y[0]);
      assign y_nx[0] = ~x_in;

      always_ff @(posedge clk) begin
        if (rst) y <= 2'b00;
        else     y <= y_nx;
      end

      assign u_out = y[1] & y[0];
    end else if (ENC == 1) begin : g_hot
      logic [3:0] h;
      logic [3:0] h_nx;
      logic       legal;

      assign legal = (h != 4'b0000) && ((h & (h - 4'd1)) == 4'b0000);

      assign h_nx[0] = ~legal | (x_in & (h[0] | h[2] | h[3]));
      assign h_nx[1] =  legal & ~x_in & (h[0] | h[1] | h[3]);
      assign h_nx[2] =  legal &  x_in & h[1];
      assign h_nx[3] =  legal & ~x_in & h[2];

      always_ff @(posedge clk) begin
        if (rst) h <= 4'b0001;
        else     h <= h_nx;
      end

      assign u_out = h[3] & legal;
    end else begin : g_bad
      $error("moore_seq: ENC must be 0 (binary) or 1 (one-hot)");
      assign u_out = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/moore_seq_chk.sv
module moore_seq_chk (
  input logic clk,
  input logic rst,
  input logic x,
  input logic u
);

  assert_rst_clears_R1: assert property (@(posedge clk) rst |=> !u);

  assert_entry_needs_zero_R5: assert property (@(posedge clk) disable iff (rst)
    x |=> !u);

  assert_accept_single_R6: assert property (@(posedge clk) disable iff (rst)
    u |=> !u);

  assert_accept_after_zero_R2: assert property (@(posedge clk) disable iff (rst)
    u |-> !$past(x));

endmodule

bind moore_seq moore_seq_chk u_chk (
  .clk(clk),
  .rst(rst),
  .x(x_in),
  .u(u_out)
);

// File: tb/moore_seq_tb.sv
module moore_seq_tb;

  typedef struct {
    logic  u_exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic u_bin, u_hot;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb[$];
  int ref_st = 0;

  always #10 clk = ~clk;

  moore_seq #(.ENC(0)) u_dut (.clk(clk), .rst(rst), .x_in(x_in), .u_out(u_bin));
  moore_seq #(.ENC(1)) u_dut_oh (.clk(clk), .rst(rst), .x_in(x_in), .u_out(u_hot));

  function automatic int ref_next(int s, logic xv);
    case (s)
      0: return xv ? 0 : 1;
      1: return xv ? 2 : 1;
      2: return xv ? 0 : 3;
      default: return xv ? 0 : 1;
    endcase
  endfunction

  task automatic drive(logic xv, logic rv, string tag);
    item_t it;
    string t;
    @(negedge clk);
    x_in = xv;
    rst  = rv;
    if (tag != "") t = tag;
    else begin
      case (ref_st)
        0: t = "R3";
        1: t = "R4";
        2: t = "R5";
        default: t = "R6";
      endcase
    end
    ref_st = rv ? 0 : ref_next(ref_st, xv);
    it.u_exp = (ref_st == 3);
    it.tag = t;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (u_bin !== it.u_exp) begin
        errors++;
        $display("FAIL %s binary u_out=%b expected=%b", it.tag, u_bin, it.u_exp);
      end
      checks++;
      if (u_hot !== it.u_exp) begin
        errors++;
        $display("FAIL %s one-hot u_out=%b expected=%b", it.tag, u_hot, it.u_exp);
      end
      checks++;
      if (u_bin !== u_hot) begin
        errors++;
        $display("FAIL R8 binary=%b one-hot=%b expected equal (%b)", u_bin, u_hot, it.u_exp);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    drive(1'b0, 1'b1, "R1");
    drive(1'b1, 1'b1, "R1");
    // R7 directed: 0,1,0 reaches accepting state, then 1 returns to S0
    drive(1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, "R7");
    drive(1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, "R7");
    drive(1'b1, 1'b0, "R7");
    // R4 hold in S1, R6 from S3 on x=0
    drive(1'b0, 1'b0, "R3");
    drive(1'b0, 1'b0, "R4");
    drive(1'b1, 1'b0, "R4");
    drive(1'b0, 1'b0, "R5");
    drive(1'b0, 1'b0, "R6");
    drive(1'b1, 1'b0, "R4");
    drive(1'b1, 1'b0, "R5");
    // R1: reset wins over an entry into S3
    drive(1'b0, 1'b0, "");
    drive(1'b1, 1'b0, "");
    drive(1'b0, 1'b1, "R1");
    // R1: reset while in S3
    drive(1'b0, 1'b0, "");
    drive(1'b1, 1'b0, "");
    drive(1'b0, 1'b0, "R2");
    drive(1'b0, 1'b1, "R1");
    drive(1'b0, 1'b0, "R1");
    drive(1'b1, 1'b0, "R1");
    drive(1'b0, 1'b0, "R1");
    // random traffic, both encodings against the model (R8)
    for (int i = 0; i < 1200; i++) begin
      logic rv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rv = (i % 97) == 96;
      drive(lfsr[0] & lfsr[3] | lfsr[5] & ~lfsr[0], rv, rv ? "R1" : "");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule